// File: doc/BRIEF.md
# Instruction Address Breakpoint Comparator

This block watches the address of every instruction the core executes. It raises a breakpoint request when that address matches one of a small set of programmed comparators. Each comparator holds one word address and a two-bit match field. The match field chooses whether the half-word at the lower address of that word triggers, the half-word at the upper address triggers, or both trigger. A control register carries a global enable and reports how many comparators the instance provides. Writes to the control register are accepted only when they carry a key bit.

A debug host programs the comparators through a simple register write/read port. The core's fetch logic presents each executed instruction address with a valid strobe. The hit output is asserted combinationally, in the same cycle as the valid address, so the halting logic sees exactly one hit cycle per matching instruction. Halting the core and software breakpoint instructions are handled elsewhere.

Top module: `bkpt_unit`

## Requirements
- R1: After reset the control register reads `NUM_CMP << 4` with the enable bit clear, every comparator register reads 0, and no hit is raised.
- R2: A write to the control register (byte offset 0x00) updates the global enable from data bit 0 only when data bit 1 is 1. Without that bit the whole write is discarded.
- R3: A control register read returns the comparator count in bits 7:4 and the global enable in bit 0. All other bits read 0, including the key bit 1.
- R4: The register for comparator k sits at byte offset 0x10 + 4k. It stores the match field in bits 31:30, the compare address in bits 28:2 and the comparator enable in bit 0. Bits 29 and 1 read as 0.
- R5: No hit is raised while the global enable is clear, whatever the comparator settings.
- R6: A comparator raises no hit unless its enable bit is set and its match field is nonzero.
- R7: The match field codes are 00 none, 01 lower half-word (address bit 1 = 0), 10 upper half-word (address bit 1 = 1), 11 both.
- R8: A match compares instruction address bits 28:2 with the stored address. Address bits 31:29 and bit 0 are ignored.
- R9: `bkpt_hit_o` is asserted in the same cycle as a matching `fetch_valid_i`, and never while `fetch_valid_i` is low.
- R10: Hits from all comparators are ORed into the single `bkpt_hit_o`.
- R11: Offsets that map to no register read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| fetch_valid_i | input | 1 | An instruction address is presented this cycle |
| fetch_addr_i | input | 32 | Executed instruction address |
| bkpt_hit_o | output | 1 | Breakpoint request, same cycle as the matching address |

## Verification
The bench programs four comparators, one with each match code (including one that is disabled), and then walks a table of instruction addresses. The table covers the lower and upper half-word of each word, neighbouring words, and addresses that differ only in bits 31:29 or bit 0. These cases separate a correct half-word select from a plain word compare, and a correct 27-bit compare from a full 32-bit or narrower one. Directed cases then toggle the global enable with and without the key bit, clear a match field, hit two comparators at once, write all-ones to check reserved bits, and write to unmapped offsets.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned MAX_CMP  = 4;
  localparam int unsigned CADDR_W  = 27;  // address bits 28:2

  typedef enum logic [1:0] {
    MATCH_NONE = 2'b00,
    MATCH_LO   = 2'b01,
    MATCH_HI   = 2'b10,
    MATCH_BOTH = 2'b11
  } match_e;

  typedef struct packed {
    logic [1:0]         match;
    logic [CADDR_W-1:0] addr;
    logic               en;
  } cmp_cfg_t;

  function automatic cmp_cfg_t cfg_from_word(logic [31:0] d);
    cmp_cfg_t c;
    c.match = d[31:30];
    c.addr  = d[28:2];
    c.en    = d[0];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(cmp_cfg_t c);
    return {c.match, 1'b0, c.addr, 1'b0, c.en};
  endfunction
endpackage

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic        en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                en_q <= 1'b0;
    else if (wr_i && wdata_i[1]) en_q <= wdata_i[0];
  end

  assign en_o = en_q;

  // R2
  unkeyed_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wdata_i[1]) |=> $stable(en_o));

  // R2
  keyed_write_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[1]) |=> (en_o == $past(wdata_i[0])));
endmodule

// File: rtl/bkpt_cmp.sv
module bkpt_cmp
  import bkpt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        glob_en_i,
  input  logic        fetch_valid_i,
  input  logic [31:0] fetch_addr_i,
  output cmp_cfg_t    cfg_o,
  output logic        hit_o
);
  cmp_cfg_t cfg_q;
  logic     word_eq;
  logic     half_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (wr_i) cfg_q <= cfg_from_word(wdata_i);
  end

  assign word_eq = (fetch_addr_i[28:2] == cfg_q.addr);

  always_comb begin
    unique case (match_e'(cfg_q.match))
      MATCH_LO:   half_ok = !fetch_addr_i[1];
      MATCH_HI:   half_ok =  fetch_addr_i[1];
      MATCH_BOTH: half_ok = 1'b1;
      default:    half_ok = 1'b0;
    endcase
  end

  assign hit_o = fetch_valid_i && glob_en_i && cfg_q.en && word_eq && half_ok;
  assign cfg_o = cfg_q;

  // R4
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(cfg_o));

  // R6
  hit_needs_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (cfg_o.en && cfg_o.match != 2'b00));
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned NUM_CMP = 4,
  parameter int unsigned REG_AW  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              fetch_valid_i,
  input  logic [31:0]       fetch_addr_i,
  output logic              bkpt_hit_o
);
  localparam int unsigned IDX_W    = REG_AW - 2;
  localparam int unsigned CTRL_IDX = 0;
  localparam int unsigned CMP_BASE = 4;

  logic [IDX_W-1:0]   idx;
  logic               glob_en;
  logic [NUM_CMP-1:0] cmp_hit;
  cmp_cfg_t           cmp_cfg [NUM_CMP];

  assign idx = reg_addr_i[REG_AW-1:2];

  bkpt_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_we_i && idx == IDX_W'(CTRL_IDX)),
    .wdata_i (reg_wdata_i),
    .en_o    (glob_en)
  );

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    bkpt_cmp u_cmp (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .wr_i          (reg_we_i && idx == IDX_W'(CMP_BASE + k)),
      .wdata_i       (reg_wdata_i),
      .glob_en_i     (glob_en),
      .fetch_valid_i (fetch_valid_i),
      .fetch_addr_i  (fetch_addr_i),
      .cfg_o         (cmp_cfg[k]),
      .hit_o         (cmp_hit[k])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (idx == IDX_W'(CTRL_IDX))
      reg_rdata_o = {24'd0, 4'(NUM_CMP), 3'b000, glob_en};
    for (int k = 0; k < NUM_CMP; k++)
      if (idx == IDX_W'(CMP_BASE + k)) reg_rdata_o = cfg_to_word(cmp_cfg[k]);
  end

  assign bkpt_hit_o = |cmp_hit;

  // R9
  no_hit_without_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> !bkpt_hit_o);

  // R5
  hit_needs_glob_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bkpt_hit_o |-> glob_en);

  // R10
  hit_or_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_hit != '0) |-> bkpt_hit_o);
endmodule

// File: tb/bkpt_unit_tb_top.sv
module bkpt_unit_tb_top;
  localparam int REG_AW = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              reg_we_i = 1'b0;
  logic [REG_AW-1:0] reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              fetch_valid_i = 1'b0;
  logic [31:0]       fetch_addr_i = '0;
  logic              bkpt_hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bkpt_unit #(.NUM_CMP(4), .REG_AW(REG_AW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .fetch_valid_i(fetch_valid_i), .fetch_addr_i(fetch_addr_i), .bkpt_hit_o(bkpt_hit_o)
  );

  // {valid, address, expected hit}
  typedef struct packed { logic v; logic [31:0] a; logic h; } vec_t;
  localparam vec_t VECS [14] = '{
    '{1'b1, 32'h0000_1000, 1'b1},  // R7 lower half allowed
    '{1'b1, 32'h0000_1002, 1'b0},  // R7 upper half not allowed
    '{1'b0, 32'h0000_1000, 1'b0},  // R9 no valid
    '{1'b1, 32'h0000_2004, 1'b0},  // R7 lower not allowed
    '{1'b1, 32'h0000_2006, 1'b1},  // R7 upper allowed
    '{1'b1, 32'h1FFF_FFFC, 1'b1},  // R7 both, lower
    '{1'b1, 32'h1FFF_FFFE, 1'b1},  // R7 both, upper
    '{1'b1, 32'h0000_3000, 1'b0},  // R6 comparator disabled
    '{1'b1, 32'hE000_1000, 1'b1},  // R8 bits 31:29 ignored
    '{1'b1, 32'h0000_1001, 1'b1},  // R8 bit 0 ignored
    '{1'b1, 32'h0000_1004, 1'b0},  // R8 next word
    '{1'b1, 32'h0000_0000, 1'b0},  // R8 zero address
    '{1'b1, 32'h0000_3002, 1'b0},  // R6 disabled, upper
    '{1'b1, 32'h0FFF_FFFC, 1'b0}   // R8 bit 28 compared
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [REG_AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(string req, logic [REG_AW-1:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr_i = a;
    #1 chk(req, reg_rdata_o, exp);
  endtask

  task automatic fetch(string req, logic v, logic [31:0] a, logic exp);
    @(negedge clk);
    fetch_valid_i = v; fetch_addr_i = a;
    #1 chk(req, {31'd0, bkpt_hit_o}, {31'd0, exp});
    @(negedge clk);
    fetch_valid_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    rd("R1", 6'h00, 32'h0000_0040);
    for (int k = 0; k < 4; k++) rd("R1", 6'(16 + 4*k), 32'h0);
    fetch("R1", 1'b1, 32'h0000_0000, 1'b0);

    wr(6'h10, 32'h4000_1001);
    wr(6'h14, 32'h8000_2005);
    wr(6'h18, 32'hDFFF_FFFD);
    wr(6'h1C, 32'hC000_3000);
    // R5 global enable still clear
    fetch("R5", 1'b1, 32'h0000_1000, 1'b0);
    wr(6'h00, 32'h0000_0003);
    rd("R3", 6'h00, 32'h0000_0041);

    for (int i = 0; i < 14; i++) fetch("R7/R8/R9", VECS[i].v, VECS[i].a, VECS[i].h);

    // R2 unkeyed write discarded
    wr(6'h00, 32'hFFFF_FFFC);
    rd("R2", 6'h00, 32'h0000_0041);
    wr(6'h00, 32'h0000_0002);
    rd("R2", 6'h00, 32'h0000_0040);
    fetch("R5", 1'b1, 32'h0000_1000, 1'b0);
    wr(6'h00, 32'h0000_0001);
    rd("R2", 6'h00, 32'h0000_0040);
    wr(6'h00, 32'h0000_0003);
    fetch("R5", 1'b1, 32'h0000_1000, 1'b1);

    // R6 match field 00 with comparator enabled
    wr(6'h10, 32'h0000_1001);
    fetch("R6", 1'b1, 32'h0000_1000, 1'b0);
    // R10 two comparators match the same word
    wr(6'h10, 32'h4000_2005);
    fetch("R10", 1'b1, 32'h0000_2004, 1'b1);
    fetch("R10", 1'b1, 32'h0000_2006, 1'b1);
    // R4 reserved bits read 0
    wr(6'h14, 32'hFFFF_FFFF);
    rd("R4", 6'h14, 32'hDFFF_FFFD);

    // R11 unmapped offsets
    wr(6'h04, 32'hFFFF_FFFF);
    wr(6'h3C, 32'hFFFF_FFFF);
    wr(6'h20, 32'hFFFF_FFFF);
    rd("R11", 6'h04, 32'h0);
    rd("R11", 6'h20, 32'h0);
    rd("R11", 6'h00, 32'h0000_0041);
    rd("R11", 6'h10, 32'h4000_2005);
    rd("R11", 6'h18, 32'hDFFF_FFFD);
    rd("R11", 6'h1C, 32'hC000_3000);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog got=timeout exp=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule